// File: doc/BRIEF.md
# Receive FIFO and Status Logic for a UART Channel

This block sits between the receive shift register of one UART channel and the CPU. Each time the shift register finishes a character it raises a one-cycle strobe with the character's data and its break, parity-error and framing-error flags. The block stores these entries in a FIFO whose capacity is 8 entries, or 16 when deep mode is selected. When the FIFO is already full, one more character can wait in a single holding stage that stands for the shift register. When a CPU read frees a slot, that waiting character moves into the FIFO on the next clock.

The block keeps three status bits: receiver-ready, FIFO-full and overrun. Overrun records that a character completed while the FIFO was full and another character was already waiting. In that case the waiting character and its flags are lost, and the newly completed character takes its place. Overrun is sticky until the CPU issues a reset-error-status command. CPU reads return data and flags through registered outputs one clock after the read strobe.

Top module: `rx_fifo_status`

## Requirements
- R1: `stat_o` is 5 bits wide. Bit 4 is overrun, bit 1 is FIFO-full and bit 0 is receiver-ready, each 1 when the condition is true. Bits 3 and 2 always read 0.
- R2: Receiver-ready is 1 in the cycle after any character strobe, and also whenever the FIFO holds at least one entry.
- R3: A read clears receiver-ready only when it leaves the FIFO empty. Otherwise receiver-ready stays 1.
- R4: FIFO-full sets when a write brings the FIFO to its capacity. Capacity is 8 entries with `deep_mode`=0 and 16 with `deep_mode`=1. At capacity minus one, FIFO-full reads 0.
- R5: A read clears FIFO-full, except when a character is waiting in the holding stage. In that case FIFO-full stays 1.
- R6: A waiting character moves into the FIFO on the clock after a read frees a slot. Its break, parity and framing flags move with it, and FIFO order is kept.
- R7: Overrun sets in the cycle after a character strobe that arrives while the FIFO is full and a character is already waiting. The waiting character is discarded with its flags, and the new character becomes the waiting one.
- R8: Overrun stays 1 across reads and idle cycles. Only `clr_err_i` clears it. When a new overrun and `clr_err_i` arrive in the same cycle, overrun stays set.
- R9: A read while the FIFO is empty changes no status bit. The data and flag outputs keep their previous values.
- R10: With `rst_n` low at a clock edge, the FIFO and the holding stage are emptied, all status bits read 0, and the data and flag outputs read 0.
- R11: Reads return data and flags in arrival order, valid one clock after the `rd_i` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| deep_mode | input | 1 | 0: capacity 8, 1: capacity 16 (change only while empty) |
| chr_vld_i | input | 1 | One-cycle strobe: a character is complete |
| chr_data_i | input | 8 | Completed character |
| chr_brk_i | input | 1 | Break flag of the completed character |
| chr_par_i | input | 1 | Parity-error flag of the completed character |
| chr_frm_i | input | 1 | Framing-error flag of the completed character |
| rd_i | input | 1 | CPU read strobe for the FIFO |
| clr_err_i | input | 1 | Reset-error-status command |
| rd_data_o | output | 8 | Data returned by the last non-empty read |
| rd_brk_o | output | 1 | Break flag returned with `rd_data_o` |
| rd_par_o | output | 1 | Parity-error flag returned with `rd_data_o` |
| rd_frm_o | output | 1 | Framing-error flag returned with `rd_data_o` |
| stat_o | output | 5 | Status: bit 4 overrun, bit 1 FIFO-full, bit 0 receiver-ready |

## Verification
The bound checker tests several rules on every clock:
- overrun stickiness and its cause;
- receiver-ready following a strobe and falling only on a read;
- FIFO-full holding across a read while a character waits;
- the fill level never exceeding the selected capacity;
- empty reads leaving the outputs unchanged.

Other behaviour only the bench scenarios can show. These are the order and flag content of the read data, the transfer of the waiting character the clock after a read, which character an overrun discards, and that the full threshold moves from 8 to 16 with deep mode.

// File: rtl/rxf_pkg.sv
// Package: shared types for the UART receive FIFO block.
// Assumes one character is at most RXF_CHAR_W bits wide.
package rxf_pkg;
    parameter int RXF_CHAR_W = 8;

    // One stored character with its receive error flags.
    typedef struct packed {
        logic                  brk;
        logic                  par;
        logic                  frm;
        logic [RXF_CHAR_W-1:0] data;
    } rxf_ent_t;
endpackage

// File: rtl/rxf_store.sv
// Module: circular storage for receive entries with a fill counter and a
// registered read port. Assumes the caller never writes when the fill level
// has reached its selected capacity and never reads when empty.
module rxf_store
    import rxf_pkg::*;
#(
    parameter int MAX_DEPTH = 16,
    localparam int PTR_W = $clog2(MAX_DEPTH),
    localparam int CNT_W = $clog2(MAX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  rxf_ent_t         wr_ent,
    input  logic             rd_en,
    output logic [CNT_W-1:0] fill,
    output rxf_ent_t         rd_ent
);
    rxf_ent_t         mem [MAX_DEPTH];
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;

    // Store the written entry at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wptr] <= wr_ent;
        end
    end

    // Advance the pointers and the fill level, and register the read entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr   <= '0;
            rptr   <= '0;
            fill   <= '0;
            rd_ent <= '0;
        end else begin
            if (wr_en) begin
                wptr <= (wptr == PTR_W'(MAX_DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (rd_en) begin
                rptr   <= (rptr == PTR_W'(MAX_DEPTH - 1)) ? '0 : rptr + 1'b1;
                rd_ent <= mem[rptr];
            end
            fill <= fill + CNT_W'(wr_en) - CNT_W'(rd_en);
        end
    end
endmodule

// File: rtl/rxf_hold.sv
// Module: single holding stage for a character that finished while the FIFO
// was full. A load overwrites any waiting entry. Assumes load and drain never
// leave two characters needing the stage at once (the controller sees to it).
module rxf_hold
    import rxf_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  rxf_ent_t load_ent,
    input  logic     drain,
    output logic     vld,
    output rxf_ent_t ent
);
    // Capture a new waiting character, or empty the stage once it drains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= 1'b0;
            ent <= '0;
        end else if (load) begin
            vld <= 1'b1;
            ent <= load_ent;
        end else if (drain) begin
            vld <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_fifo_status.sv
// Module: receive FIFO, holding stage and status bits of one UART channel.
// Routes completed characters into the FIFO or the holding stage, detects
// overrun, and serves CPU reads. Assumes deep_mode changes only while empty
// and that chr_vld_i is a one-cycle strobe.
module rx_fifo_status
    import rxf_pkg::*;
#(
    parameter int MAX_DEPTH = 16,
    localparam int SHALLOW_DEPTH = MAX_DEPTH / 2,
    localparam int CNT_W = $clog2(MAX_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  deep_mode,
    input  logic                  chr_vld_i,
    input  logic [RXF_CHAR_W-1:0] chr_data_i,
    input  logic                  chr_brk_i,
    input  logic                  chr_par_i,
    input  logic                  chr_frm_i,
    input  logic                  rd_i,
    input  logic                  clr_err_i,
    output logic [RXF_CHAR_W-1:0] rd_data_o,
    output logic                  rd_brk_o,
    output logic                  rd_par_o,
    output logic                  rd_frm_o,
    output logic [4:0]            stat_o
);
    rxf_ent_t         new_ent;
    rxf_ent_t         hold_ent;
    rxf_ent_t         wr_ent;
    rxf_ent_t         rd_ent;
    logic [CNT_W-1:0] fill_cnt;
    logic [CNT_W-1:0] cap_lvl;
    logic [CNT_W-1:0] fill_nxt;
    logic             hold_v;
    logic             at_cap;
    logic             do_rd;
    logic             xfer;
    logic             direct_wr;
    logic             wr_en;
    logic             hold_load;
    logic             ovr_hit;
    logic             rdy_q;
    logic             full_q;
    logic             ovr_q;

    // Bundle the incoming character with its flags.
    always_comb begin
        new_ent.brk  = chr_brk_i;
        new_ent.par  = chr_par_i;
        new_ent.frm  = chr_frm_i;
        new_ent.data = chr_data_i;
    end

    // Steer characters, detect overrun and work out the next fill level.
    always_comb begin
        cap_lvl   = deep_mode ? CNT_W'(MAX_DEPTH) : CNT_W'(SHALLOW_DEPTH);
        at_cap    = (fill_cnt == cap_lvl);
        do_rd     = rd_i && (fill_cnt != '0);
        xfer      = hold_v && !at_cap;
        direct_wr = chr_vld_i && !hold_v && !at_cap;
        wr_en     = xfer || direct_wr;
        wr_ent    = xfer ? hold_ent : new_ent;
        hold_load = chr_vld_i && (hold_v || at_cap);
        ovr_hit   = chr_vld_i && hold_v && at_cap;
        fill_nxt  = fill_cnt + CNT_W'(wr_en) - CNT_W'(do_rd);
    end

    rxf_store #(.MAX_DEPTH(MAX_DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_ent (wr_ent),
        .rd_en  (do_rd),
        .fill   (fill_cnt),
        .rd_ent (rd_ent)
    );

    rxf_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hold_load),
        .load_ent (new_ent),
        .drain    (xfer),
        .vld      (hold_v),
        .ent      (hold_ent)
    );

    // Update the ready, full and sticky overrun status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q  <= 1'b0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            rdy_q  <= (fill_nxt != '0);
            full_q <= (fill_nxt == cap_lvl) || (full_q && hold_v);
            ovr_q  <= ovr_hit || (ovr_q && !clr_err_i);
        end
    end

    // Drive the outputs.
    always_comb begin
        rd_data_o = rd_ent.data;
        rd_brk_o  = rd_ent.brk;
        rd_par_o  = rd_ent.par;
        rd_frm_o  = rd_ent.frm;
        stat_o    = {ovr_q, 2'b00, full_q, rdy_q};
    end
endmodule

// File: rtl/rxf_checker.sv
// Module: protocol checker for rx_fifo_status, attached by bind.
// Assumes it observes the top's ports and its fill level and holding flag.
module rxf_checker #(
    parameter int CNT_W = 5,
    parameter int CHAR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chr_vld_i,
    input logic             rd_i,
    input logic             clr_err_i,
    input logic [4:0]       stat_o,
    input logic [CHAR_W-1:0] rd_data_o,
    input logic             hold_v,
    input logic [CNT_W-1:0] fill_cnt,
    input logic [CNT_W-1:0] cap_lvl
);
    p_ready_after_char_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chr_vld_i |=> stat_o[0]);

    p_ready_falls_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_o[0]) |-> $past(rd_i));

    p_fill_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= cap_lvl);

    p_full_kept_by_waiter_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[1] && hold_v && rd_i) |=> stat_o[1]);

    p_overrun_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_o[4]) |-> ($past(chr_vld_i) && $past(hold_v)));

    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[4] && !clr_err_i) |=> stat_o[4]);

    p_empty_read_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_o[0] && rd_i && !chr_vld_i && !hold_v) |=> ($stable(rd_data_o) && $stable(stat_o)));
endmodule

bind rx_fifo_status rxf_checker #(.CNT_W(CNT_W), .CHAR_W(rxf_pkg::RXF_CHAR_W)) u_rxf_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chr_vld_i (chr_vld_i),
    .rd_i      (rd_i),
    .clr_err_i (clr_err_i),
    .stat_o    (stat_o),
    .rd_data_o (rd_data_o),
    .hold_v    (hold_v),
    .fill_cnt  (fill_cnt),
    .cap_lvl   (cap_lvl)
);

// File: tb/test_rx_fifo_status.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver task models the requirements and queues the
// expected read results; a monitor process pops and compares them.
module test_rx_fifo_status;
    typedef struct {
        logic [7:0] d;
        logic [2:0] f;
    } ent_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       deep_mode = 1'b0;
    logic       chr_vld_i = 1'b0;
    logic [7:0] chr_data_i = '0;
    logic       chr_brk_i = 1'b0;
    logic       chr_par_i = 1'b0;
    logic       chr_frm_i = 1'b0;
    logic       rd_i = 1'b0;
    logic       clr_err_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       rd_brk_o, rd_par_o, rd_frm_o;
    logic [4:0] stat_o;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 0;

    ent_t  mq[$];
    ent_t  exp_q[$];
    string exp_tag[$];
    ent_t  m_hold;
    ent_t  last_rd;
    bit    m_hv, m_rdy, m_full, m_ovr;
    int    cap = 8;

    always #2.5 clk = ~clk;

    rx_fifo_status i_rx_fifo_status (
        .clk(clk), .rst_n(rst_n), .deep_mode(deep_mode),
        .chr_vld_i(chr_vld_i), .chr_data_i(chr_data_i),
        .chr_brk_i(chr_brk_i), .chr_par_i(chr_par_i), .chr_frm_i(chr_frm_i),
        .rd_i(rd_i), .clr_err_i(clr_err_i),
        .rd_data_o(rd_data_o), .rd_brk_o(rd_brk_o), .rd_par_o(rd_par_o),
        .rd_frm_o(rd_frm_o), .stat_o(stat_o)
    );

    task automatic check(input bit ok, input string tag, input logic [10:0] act, input logic [10:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each read result against the scoreboard queue.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            ent_t  e;
            string t;
            e = exp_q.pop_front();
            t = exp_tag.pop_front();
            check({rd_brk_o, rd_par_o, rd_frm_o, rd_data_o} === {e.f, e.d}, t,
                  {rd_brk_o, rd_par_o, rd_frm_o, rd_data_o}, {e.f, e.d});
        end
    end

    // Model one clock edge from the requirements.
    task automatic model(input bit v, input ent_t nw, input bit rd, input bit clr, input string tag);
        int sz;
        bit at_cap, hv0, ovr_set;
        sz = mq.size();
        at_cap = (sz == cap);
        hv0 = m_hv;
        ovr_set = 0;
        if (rd) begin
            if (sz > 0) begin
                last_rd = mq.pop_front();
                exp_tag.push_back({tag, "/R11 read order"});
            end else begin
                exp_tag.push_back({tag, "/R9 empty read"});
            end
            exp_q.push_back(last_rd);
        end
        if (hv0 && !at_cap) mq.push_back(m_hold);      // R6 transfer
        if (v) begin
            if (!hv0 && !at_cap) mq.push_back(nw);
            else begin
                if (hv0 && at_cap) ovr_set = 1;          // R7 drop waiter
                m_hold = nw;
                m_hv = 1;
            end
        end else if (hv0 && !at_cap) begin
            m_hv = 0;
        end
        m_ovr  = ovr_set || (m_ovr && !clr);
        m_full = (mq.size() == cap) || (m_full && hv0);
        m_rdy  = (mq.size() != 0);
    endtask

    // Driver: apply one cycle of stimulus, then compare the status.
    task automatic step(input bit v, input logic [7:0] d, input logic [2:0] fl,
                        input bit rd, input bit clr, input string tag);
        ent_t nw;
        logic [4:0] es;
        nw.d = d;
        nw.f = fl;
        chr_vld_i = v; chr_data_i = d; {chr_brk_i, chr_par_i, chr_frm_i} = fl;
        rd_i = rd; clr_err_i = clr;
        @(posedge clk);
        model(v, nw, rd, clr, tag);
        @(negedge clk);
        chr_vld_i = 0; rd_i = 0; clr_err_i = 0;
        es = {m_ovr, 2'b00, m_full, m_rdy};
        check(stat_o === es, {tag, " status"}, {6'd0, stat_o}, {6'd0, es});
    endtask

    task automatic do_reset(input bit deep);
        rst_n = 0;
        deep_mode = deep;
        cap = deep ? 16 : 8;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        mq.delete();
        m_hv = 0; m_rdy = 0; m_full = 0; m_ovr = 0;
        last_rd.d = '0; last_rd.f = '0;
        check(stat_o === 5'b0, "R10 reset status", {6'd0, stat_o}, 11'd0);
        check({rd_brk_o, rd_par_o, rd_frm_o, rd_data_o} === 11'd0, "R10 reset data",
              {rd_brk_o, rd_par_o, rd_frm_o, rd_data_o}, 11'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset(0);
        // R1 R2 R3: a few characters, read back with ready holding until empty
        step(1, 8'h11, 3'b100, 0, 0, "R2 ready after char");
        step(1, 8'h22, 3'b010, 0, 0, "R1 status bits");
        step(1, 8'h33, 3'b001, 0, 0, "R2 ready");
        step(0, 0, 0, 1, 0, "R3 ready kept");
        step(0, 0, 0, 1, 0, "R3 ready kept");
        step(0, 0, 0, 1, 0, "R3 ready cleared on empty");
        // R9: empty read keeps data and status
        step(0, 0, 0, 1, 0, "R9 empty read");
        step(0, 0, 0, 0, 0, "R9 idle");
        // R4: shallow capacity 8
        for (int i = 0; i < 8; i++) step(1, 8'h40 + 8'(i), 3'(i), 0, 0, "R4 fill shallow");
        // R5: ninth char waits; read keeps full
        step(1, 8'h48, 3'b101, 0, 0, "R5 waiter");
        step(0, 0, 0, 1, 0, "R5 full kept on read");
        step(0, 0, 0, 0, 0, "R6 waiter moves in");
        // R7: overrun drops the waiter, new char takes its place
        step(1, 8'h49, 3'b110, 0, 0, "R7 new waiter");
        step(1, 8'h4A, 3'b011, 0, 0, "R7 overrun");
        // R8: overrun sticky across reads; clr together with new overrun keeps it
        for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 0, "R8 sticky over reads / R6 order");
        step(0, 0, 0, 1, 0, "R9 empty read after drain");
        step(0, 0, 0, 0, 1, "R8 cleared by command");
        // R8: simultaneous overrun and clear
        for (int i = 0; i < 10; i++) step(1, 8'h60 + 8'(i), 3'b000, 0, 0, "R8 refill");
        step(1, 8'h6A, 3'b111, 0, 1, "R8 set wins over clear");
        step(0, 0, 0, 0, 0, "R8 hold");
        // R10: reset mid-stream, then deep mode R4
        do_reset(1);
        for (int i = 0; i < 15; i++) step(1, 8'h80 + 8'(i), 3'b000, 0, 0, "R4 deep not full");
        step(1, 8'h8F, 3'b010, 0, 0, "R4 deep full at 16");
        step(1, 8'h90, 3'b001, 1, 0, "R5 waiter with read");
        for (int i = 0; i < 18; i++) step(0, 0, 0, 1, 0, "R6 deep drain");
        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule